// File: doc/BRIEF.md
# SPI Slave Byte Shifter

This block is the receiving end of a four-wire serial link. An external master drives the serial clock, the master-out data line and an active-low select. The block shifts one word in from the master-out line and, during the same transfer, shifts a word of its own out on the master-in line. The serial pins are sampled by a faster system clock. The block supports all four combinations of clock polarity and clock phase. It shifts either most-significant or least-significant bit first.

On the parallel side, a load strobe latches the next word to send. Each completed word is copied into a receive register, which keeps its value until the next completed word replaces it. Completion produces a one-cycle pulse and sets a sticky flag, and an acknowledge strobe clears the flag. The master-in line has its own output enable, so several slaves can share it.

Top module: `spi_slv_top`

## Requirements
- R1: The four modes set by the polarity input (0: idle-low clock, 1: idle-high clock) and the phase input work as follows. With phase 0, data is captured on the first edge of each clock period. With phase 1, data is captured on the second edge. In every mode the received word equals the bits the master sent.
- R2: With phase 0, the first outgoing bit appears on the master-in line within a few system cycles of select falling, before any serial clock edge.
- R3: With phase 0, once a word has completed, further clock pulses while select stays low do not start a new word: no completion pulse occurs and the receive register is unchanged. Select must rise and fall again.
- R4: With phase 1, the first clock edge starts the word. Back-to-back words are accepted while select stays low, and the latched transmit word is sent again for each one.
- R5: The order input selects the bit order: 0 sends and receives the most-significant bit first, and 1 sends and receives the least-significant bit first.
- R6: The receive register changes only when a word completes, and it then holds that word.
- R7: The master-in output enable is 1 while the synchronized select is low and 0 while it is high.
- R8: A one-cycle completion pulse follows the last capture edge of a word, and a sticky full flag is set with it. The acknowledge strobe clears the flag. If a set and a clear land in the same cycle, the set wins.
- R9: If select rises before a whole word has been captured, the partial word is discarded and the next transfer starts from bit zero.
- R10: After reset the receive register is 0, the full flag is 0 and the output enable is 0.
- R11: The load strobe latches the transmit word. That word is what the next transfer shifts out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cpol_i | input | 1 | Clock polarity, 1 = idle-high serial clock |
| cpha_i | input | 1 | Clock phase, 1 = capture on the second edge |
| lsb_first_i | input | 1 | Bit order, 1 = least-significant bit first |
| sck_i | input | 1 | Serial clock from the master |
| ssn_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the master-in driver |
| tx_data_i | input | WIDTH | Word to transmit |
| tx_load_i | input | 1 | Strobe that latches tx_data_i |
| rx_data_o | output | WIDTH | Last completed received word |
| rx_done_o | output | 1 | One-cycle completion pulse |
| rx_full_o | output | 1 | Sticky completion flag |
| rx_ack_i | input | 1 | Strobe that clears rx_full_o |

## Verification
The bench builds the block with WIDTH = 8 and SYNC_STAGES = 2. It drives the serial clock with a half-period of eight system cycles. That period is wide enough for the three-cycle path through the synchronizer and edge detector to settle before the master samples the master-in line. With these values, one bench run covers all four clock modes and both bit orders. It also covers a word cut short by an early select rise and back-to-back phase-1 words under one select. The bench also sends extra clock pulses after a phase-0 word, which must not produce a new completion.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    // Widest word the helper functions handle
    localparam int MAXW = 32;

    typedef logic [MAXW-1:0] word_t;

    // Static link configuration
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
    } spi_mode_t;

    // Per-cycle events seen on the synchronized pins
    typedef struct packed {
        logic capture;   // sample the data line now
        logic launch;    // present the next outgoing bit now
        logic sel_fall;  // select has just gone low
        logic sel_rise;  // select has just gone high
        logic sel_low;   // select is currently asserted
        logic mosi;      // synchronized data bit
    } spi_evt_t;

    // Bit that leaves the shifter first
    function automatic logic head_bit(word_t v, logic lsb, int w);
        return lsb ? v[0] : v[w-1];
    endfunction

    // Advance the outgoing shifter by one position
    function automatic word_t advance_out(word_t v, logic lsb);
        return lsb ? (v >> 1) : (v << 1);
    endfunction

    // Insert a received bit on the correct side
    function automatic word_t insert_in(word_t v, logic b, logic lsb, int w);
        word_t r;
        if (lsb) begin
            r = v >> 1;
            r[w-1] = b;
        end else begin
            r = {v[MAXW-2:0], b};
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [STAGES-1:0][N-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
    import spi_slv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  spi_mode_t mode,
    input  logic      sck_s,
    input  logic      ssn_s,
    input  logic      mosi_s,
    output spi_evt_t  evt
);

    logic sck_q;
    logic ssn_q;
    logic rise;
    logic fall;
    logic lead;
    logic trail;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            ssn_q <= 1'b1;
        end else begin
            sck_q <= sck_s;
            ssn_q <= ssn_s;
        end
    end

    always_comb begin
        rise  = sck_s & ~sck_q;
        fall  = ~sck_s & sck_q;
        // First edge of a clock period leaves the idle level
        lead  = mode.cpol ? fall : rise;
        trail = mode.cpol ? rise : fall;

        evt.sel_low  = ~ssn_s;
        evt.sel_fall = ssn_q & ~ssn_s;
        evt.sel_rise = ~ssn_q & ssn_s;
        evt.mosi     = mosi_s;
        evt.capture  = ~ssn_s & (mode.cpha ? trail : lead);
        evt.launch   = ~ssn_s & (mode.cpha ? lead : trail);
    end

    AST_CAP_LAUNCH_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(evt.capture && evt.launch)); // R1

    AST_NO_EVT_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        ssn_s |-> !(evt.capture || evt.launch)); // R7

endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
    import spi_slv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  spi_mode_t        mode,
    input  spi_evt_t         evt,
    input  logic [WIDTH-1:0] tx_data,
    input  logic             tx_load,
    input  logic             rx_ack,
    output logic             miso,
    output logic [WIDTH-1:0] rx_data,
    output logic             rx_done,
    output logic             rx_full
);

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic [WIDTH-1:0] tx_hold_q;
    logic [WIDTH-1:0] tx_sh_q;
    logic [WIDTH-1:0] rx_sh_q;
    logic [WIDTH-1:0] rx_data_q;
    logic [WIDTH-1:0] rx_next;
    logic [CW-1:0]    cnt_q;
    logic             armed_q;
    logic             miso_q;
    logic             done_q;
    logic             full_q;

    always_comb begin
        rx_next = WIDTH'(insert_in(word_t'(rx_sh_q), evt.mosi, mode.lsb_first, WIDTH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_hold_q <= '0;
            tx_sh_q   <= '0;
            rx_sh_q   <= '0;
            rx_data_q <= '0;
            cnt_q     <= '0;
            armed_q   <= 1'b0;
            miso_q    <= 1'b0;
            done_q    <= 1'b0;
            full_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tx_load) begin
                tx_hold_q <= tx_data;
            end
            if (rx_ack) begin
                full_q <= 1'b0;
            end

            if (evt.sel_rise) begin
                // Abort: any partial word is dropped
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else if (evt.sel_fall) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
                if (!mode.cpha) begin
                    miso_q  <= head_bit(word_t'(tx_hold_q), mode.lsb_first, WIDTH);
                    tx_sh_q <= WIDTH'(advance_out(word_t'(tx_hold_q), mode.lsb_first));
                end else begin
                    tx_sh_q <= tx_hold_q;
                end
            end else if (evt.sel_low && armed_q) begin
                if (evt.capture) begin
                    rx_sh_q <= rx_next;
                    if (cnt_q == LAST) begin
                        cnt_q     <= '0;
                        rx_data_q <= rx_next;
                        done_q    <= 1'b1;
                        full_q    <= 1'b1;
                        if (!mode.cpha) begin
                            armed_q <= 1'b0;
                        end else begin
                            tx_sh_q <= tx_hold_q;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                if (evt.launch) begin
                    miso_q  <= head_bit(word_t'(tx_sh_q), mode.lsb_first, WIDTH);
                    tx_sh_q <= WIDTH'(advance_out(word_t'(tx_sh_q), mode.lsb_first));
                end
            end
        end
    end

    assign miso    = miso_q;
    assign rx_data = rx_data_q;
    assign rx_done = done_q;
    assign rx_full = full_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8

    AST_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
        done_q |-> full_q); // R8

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(rx_data_q)); // R6

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        evt.sel_rise |=> (cnt_q == '0 && !armed_q)); // R9

    AST_DISARMED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !evt.sel_fall) |=> !done_q); // R3

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R1

endmodule

// File: rtl/spi_slv_top.sv
module spi_slv_top
    import spi_slv_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic             lsb_first_i,
    input  logic             sck_i,
    input  logic             ssn_i,
    input  logic             mosi_i,
    output logic             miso_o,
    output logic             miso_oe_o,
    input  logic [WIDTH-1:0] tx_data_i,
    input  logic             tx_load_i,
    output logic [WIDTH-1:0] rx_data_o,
    output logic             rx_done_o,
    output logic             rx_full_o,
    input  logic             rx_ack_i
);

    spi_mode_t  mode;
    spi_evt_t   evt;
    logic [2:0] pins_s;

    assign mode = '{cpol: cpol_i, cpha: cpha_i, lsb_first: lsb_first_i};

    // Order: sck, select, data; select resets inactive
    spi_slv_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck_i, ssn_i, mosi_i}),
        .q   (pins_s)
    );

    spi_slv_edge i_edge (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .sck_s  (pins_s[2]),
        .ssn_s  (pins_s[1]),
        .mosi_s (pins_s[0]),
        .evt    (evt)
    );

    spi_slv_shift #(
        .WIDTH (WIDTH)
    ) i_shift (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .evt     (evt),
        .tx_data (tx_data_i),
        .tx_load (tx_load_i),
        .rx_ack  (rx_ack_i),
        .miso    (miso_o),
        .rx_data (rx_data_o),
        .rx_done (rx_done_o),
        .rx_full (rx_full_o)
    );

    assign miso_oe_o = evt.sel_low;

    AST_OE_RESET: assert property (@(posedge clk)
        rst |=> !miso_oe_o); // R10

endmodule

// File: tb/test_spi_slv_top.sv
module test_spi_slv_top;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
    logic       sck = 1'b0, ssn = 1'b1, mosi = 1'b0;
    logic       miso, miso_oe;
    logic [7:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic [7:0] rx_data;
    logic       rx_done, rx_full;
    logic       rx_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    spi_slv_top #(.WIDTH(8), .SYNC_STAGES(2)) i_spi_slv_top (
        .clk(clk), .rst(rst), .cpol_i(cpol), .cpha_i(cpha), .lsb_first_i(lsb),
        .sck_i(sck), .ssn_i(ssn), .mosi_i(mosi), .miso_o(miso), .miso_oe_o(miso_oe),
        .tx_data_i(tx_data), .tx_load_i(tx_load), .rx_data_o(rx_data),
        .rx_done_o(rx_done), .rx_full_o(rx_full), .rx_ack_i(rx_ack)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on every completion pulse
    always @(negedge clk) begin
        if (!rst && rx_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected completion", rx_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_data == e, "R1 received word", rx_data, e);
                chk(rx_full == 1'b1, "R8 full set with pulse", rx_full, 1);
            end
        end
    end

    task automatic set_mode(input logic p, input logic h, input logic o);
        cpol = p; cpha = h; lsb = o; sck = p;
        wait_h();
    endtask

    task automatic load_tx(input logic [7:0] b);
        @(negedge clk); tx_data = b; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic shift_bits(input logic [7:0] mb, input logic [7:0] sb,
                              input int n, input bit check_out);
        for (int i = 0; i < n; i++) begin
            int idx;
            idx = lsb ? i : 7 - i;
            if (!cpha) begin
                mosi = mb[idx];
                wait_h();
                if (check_out)
                    chk(miso_oe && miso == sb[idx],
                        (i == 0) ? "R2 first bit before clock" : "R5 outgoing bit",
                        miso, sb[idx]);
                sck = ~cpol;
                wait_h();
                sck = cpol;
            end else begin
                sck = ~cpol;
                mosi = mb[idx];
                wait_h();
                if (check_out)
                    chk(miso_oe && miso == sb[idx], "R4 outgoing bit", miso, sb[idx]);
                sck = cpol;
                wait_h();
            end
        end
        wait_h();
    endtask

    task automatic xfer(input logic [7:0] mb, input logic [7:0] sb);
        exp_q.push_back(mb);
        ssn = 1'b0;
        wait_h();
        shift_bits(mb, sb, 8, 1'b1);
        ssn = 1'b1;
        wait_h();
        chk(miso_oe == 1'b0, "R7 enable released", miso_oe, 0);
        wait_h();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(rx_data == 8'h00, "R10 reset data", rx_data, 0);
        chk(rx_full == 1'b0, "R10 reset full", rx_full, 0);
        chk(miso_oe == 1'b0, "R10 reset enable", miso_oe, 0);

        // R1 R2 R11 mode 0, MSB first
        set_mode(1'b0, 1'b0, 1'b0);
        load_tx(8'hA5);
        xfer(8'h3C, 8'hA5);
        chk(rx_data == 8'h3C, "R6 word held", rx_data, 8'h3C);

        // R8 acknowledge clears the flag
        @(negedge clk); rx_ack = 1'b1;
        @(negedge clk); rx_ack = 1'b0;
        chk(rx_full == 1'b0, "R8 ack clears full", rx_full, 0);

        // R3 extra clocks under a held select, phase 0
        load_tx(8'h0F);
        exp_q.push_back(8'h96);
        ssn = 1'b0;
        wait_h();
        chk(miso_oe == 1'b1, "R7 enable while selected", miso_oe, 1);
        shift_bits(8'h96, 8'h0F, 8, 1'b1);
        shift_bits(8'h55, 8'h00, 8, 1'b0);
        chk(rx_data == 8'h96, "R3 no second word", rx_data, 8'h96);
        ssn = 1'b1;
        wait_h(); wait_h();

        // R9 partial word dropped, then a full word
        ssn = 1'b0;
        wait_h();
        shift_bits(8'hFF, 8'h0F, 5, 1'b0);
        ssn = 1'b1;
        wait_h(); wait_h();
        chk(rx_data == 8'h96, "R9 partial not stored", rx_data, 8'h96);
        xfer(8'h81, 8'h0F);
        chk(rx_data == 8'h81, "R9 clean restart", rx_data, 8'h81);

        // R5 mode 0, LSB first
        set_mode(1'b0, 1'b0, 1'b1);
        load_tx(8'hC1);
        xfer(8'h2D, 8'hC1);

        // R1 mode 2 (idle-high, phase 0), MSB first
        set_mode(1'b1, 1'b0, 1'b0);
        load_tx(8'h6B);
        xfer(8'hE4, 8'h6B);

        // R1 mode 1 (idle-low, phase 1), LSB first
        set_mode(1'b0, 1'b1, 1'b1);
        load_tx(8'h93);
        xfer(8'h47, 8'h93);

        // R4 mode 3, two words under one select
        set_mode(1'b1, 1'b1, 1'b0);
        load_tx(8'h5A);
        exp_q.push_back(8'hC3);
        exp_q.push_back(8'h3E);
        ssn = 1'b0;
        wait_h();
        shift_bits(8'hC3, 8'h5A, 8, 1'b1);
        chk(rx_data == 8'hC3, "R4 first word", rx_data, 8'hC3);
        shift_bits(8'h3E, 8'h5A, 8, 1'b1);
        chk(rx_data == 8'h3E, "R4 second word", rx_data, 8'h3E);
        ssn = 1'b1;
        wait_h(); wait_h();

        // R6 value still held long after
        repeat (50) @(negedge clk);
        chk(rx_data == 8'h3E, "R6 hold over idle", rx_data, 8'h3E);
        chk(exp_q.size() == 0, "R1 all words seen", exp_q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule